// File: doc/BRIEF.md
# Daisy-Chained Grayscale PWM Chain Controller

This block generates all timing for a serial chain of 16-channel, 12-bit constant-current LED driver devices. It runs the grayscale clock in frames of 4096 periods, holds the blanking strobe between frames, serialises one 192-bit record per device on a clock-and-data pair that idles low, and pulses a latch strobe inside blanking so that the devices move the new record into their output registers.

A host loads 12-bit levels one channel at a time into a host-side array and then pulses a commit strobe. A full frame is sent every cycle from a transmit buffer. The host values are copied into that buffer only at the start of a transfer and only if a commit is pending, so a frame on the wire is never a mix of old and new levels. The transmit buffer is cleared by reset, so every output stays dark until the host commits data.

A compile-time parameter picks the transfer schedule. With the in-cycle schedule the next frame is shifted while the current grayscale frame runs, and blanking stays at its minimum length. With the in-blanking schedule the whole frame is shifted while blanking is held, on every cycle, and blanking stretches by the shift time. The serial clock divider, the grayscale clock divider and the chain length are parameters.

Top module: `gs_chain_timing`

## Requirements
- R1: Between the fall of `blank_o` and its next rise, `gs_clk_o` has exactly 4096 rising edges; `gs_clk_o` is low whenever `blank_o` is high.
- R2: Every transfer has exactly N_DEV*192 rising edges of `ser_clk_o`; `ser_clk_o` idles low and `ser_dat_o` does not change on the cycle `ser_clk_o` rises.
- R3: Bit order on the wire: channel N_DEV*16-1 is sent first and channel 0 last, each level most significant bit first, with no padding, which equals the 12-bit levels packed two per three bytes, high bits first.
- R4: In-cycle schedule (XFER_IN_BLANK=0): after the first frame, all serial bits of a frame are sent while `blank_o` is low, and `blank_o` is high for exactly 4 system clocks per cycle.
- R5: In-blanking schedule (XFER_IN_BLANK=1): `ser_clk_o` is high only while `blank_o` is high, and `blank_o` is high for exactly 2*SCK_DIV*N_DEV*192+4 system clocks per cycle.
- R6: In the in-blanking schedule, a complete frame is sent in every blanking interval even when no commit is pending.
- R7: A full frame is sent every cycle from the transmit buffer. Host writes (`host_we`, channel `host_chan` at bits [12*k+11:12*k] of the frame) reach the buffer only if `host_commit` was pulsed before the transfer starts; without a commit, the wire keeps the previous levels. The pending commit clears once it is taken.
- R8: Under reset `blank_o` is 1 and `latch_o`, `ser_clk_o`, `ser_dat_o`, `gs_clk_o` are 0; the transmit buffer is zero, so the first latched frame after reset is all zeros.
- R9: `latch_o` is one clock wide, high only while `blank_o` is high and `ser_clk_o` is low, at least one clock after the last serial bit; `blank_o` falls one clock after `latch_o` falls.
- R10: Host writes and commits that arrive while a transfer is in progress leave that frame unchanged and appear in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Write one channel level into the host array |
| host_chan | input | $clog2(N_DEV*16) | Channel index of the write |
| host_level | input | 12 | Level value of the write |
| host_commit | input | 1 | Mark the host array as new data for the next transfer |
| gs_clk_o | output | 1 | Grayscale clock to the chain |
| blank_o | output | 1 | Blanking strobe, outputs off while high |
| latch_o | output | 1 | Latch strobe, moves shifted data to the outputs |
| ser_clk_o | output | 1 | Serial clock, idles low |
| ser_dat_o | output | 1 | Serial data, valid at the rising serial clock edge |

## Verification
A wrong sequencer state shows within one grayscale frame as a blanking width or a grayscale edge count that differs from the fixed values, or as a latch pulse outside blanking. A wrong bit counter or buffer pointer shows in the very next latched frame as a wrong serial bit count or a misplaced level, since every frame is checked bit for bit against levels built from the requirement's ordering. A stuck pending flag shows two latches after a write, as levels that change without a commit or fail to change after one.

// File: rtl/gs_chain_pkg.sv
// Package: shared constants and the cycle sequencer state type for the
// grayscale chain controller. Assumes 16 channels of 12 bits per device.
package gs_chain_pkg;

    localparam int LVL_W        = 12;
    localparam int CH_PER_DEV   = 16;
    localparam int BITS_PER_DEV = LVL_W * CH_PER_DEV;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_BLANK = 3'd1,
        ST_WAIT  = 3'd2,
        ST_LATCH = 3'd3,
        ST_REL   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/gs_clock_gen.sv
// Grayscale clock generator. Toggles gs_clk every DIV system clocks while
// run is high, counts rising edges and raises done after the falling edge
// that follows the STEPS-th rising edge. Clears itself whenever run is low.
// Assumes run stays high until done has been seen.
module gs_clock_gen #(
    parameter int DIV   = 1,
    parameter int STEPS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gs_clk,
    output logic done
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int CNT_W = $clog2(STEPS + 1);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] edges_q;
    logic             gs_q;

    assign done   = (edges_q == CNT_W'(STEPS)) && !gs_q;
    assign gs_clk = gs_q;

    // Divide the system clock and count grayscale rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q   <= '0;
            gs_q    <= 1'b0;
            edges_q <= '0;
        end else if (!done) begin
            if (div_q == DIV_W'(DIV - 1)) begin
                div_q <= '0;
                gs_q  <= ~gs_q;
                if (!gs_q) begin
                    edges_q <= edges_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // R1
    gs_low_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !gs_clk);

    // R1
    gs_edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= CNT_W'(STEPS));

endmodule

// File: rtl/frame_shifter.sv
// Frame shifter. Holds the host-side level array, the transmit buffer and
// the pending-commit flag, and serialises the transmit buffer on a mode-0
// clock/data pair when go is pulsed. The buffer is refreshed from the host
// array only at go and only when a commit is pending. Assumes go is only
// pulsed while the shifter is idle.
module frame_shifter
    import gs_chain_pkg::*;
#(
    parameter int N_DEV   = 2,
    parameter int SCK_DIV = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              host_we,
    input  logic [$clog2(N_DEV*CH_PER_DEV)-1:0] host_chan,
    input  logic [LVL_W-1:0]                  host_level,
    input  logic                              host_commit,
    input  logic                              go,
    output logic                              busy,
    output logic                              ser_clk,
    output logic                              ser_dat
);
    localparam int N_CH   = N_DEV * CH_PER_DEV;
    localparam int FRAME  = N_DEV * BITS_PER_DEV;
    localparam int IDX_W  = $clog2(FRAME);
    localparam int DIV_W  = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;

    logic [FRAME-1:0] host_q;
    logic [FRAME-1:0] shadow_q;
    logic             pending_q;
    logic             busy_q;
    logic             phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [DIV_W-1:0] div_q;

    // Store host channel writes; out-of-range channels are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= '0;
        end else if (host_we && (int'(host_chan) < N_CH)) begin
            host_q[int'(host_chan)*LVL_W +: LVL_W] <= host_level;
        end
    end

    // Track a pending commit; it is consumed at the next transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= (pending_q && !go) || host_commit;
        end
    end

    // Refresh the transmit buffer from the host array at a committed start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (go && pending_q) begin
            shadow_q <= host_q;
        end
    end

    // Step the serial clock phase and the bit index during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            idx_q   <= '0;
            div_q   <= '0;
        end else if (go) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            idx_q   <= '0;
            div_q   <= '0;
        end else if (busy_q) begin
            if (div_q == DIV_W'(SCK_DIV - 1)) begin
                div_q <= '0;
                if (!phase_q) begin
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    if (idx_q == IDX_W'(FRAME - 1)) begin
                        busy_q <= 1'b0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign ser_clk = busy_q && phase_q;
    assign ser_dat = busy_q ? shadow_q[FRAME - 1 - int'(idx_q)] : 1'b0;

    // R2
    dat_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dat));

    // R10
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy_q);

    // R10
    buffer_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(shadow_q));

endmodule

// File: rtl/cycle_seq.sv
// Cycle sequencer. Walks run -> blank -> wait -> latch -> release and
// issues the transfer start. In-cycle schedule: transfer starts as the
// grayscale frame starts. In-blanking schedule: transfer starts at each
// blank entry. The first blank after reset always carries a transfer so
// that the cleared buffer reaches the chain. Assumes busy comes from the
// shifter started by go.
module cycle_seq
    import gs_chain_pkg::*;
#(
    parameter bit XFER_IN_BLANK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gs_done,
    input  logic xfer_busy,
    output logic run,
    output logic blank,
    output logic latch,
    output logic go
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic       first_q;

    // Next-state and transfer-start decode.
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        case (state_q)
            ST_RUN:   if (gs_done) state_d = ST_BLANK;
            ST_BLANK: begin
                state_d = ST_WAIT;
                go      = XFER_IN_BLANK || first_q;
            end
            ST_WAIT:  if (!xfer_busy) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_REL;
            ST_REL: begin
                state_d = ST_RUN;
                go      = !XFER_IN_BLANK;
            end
            default:  state_d = ST_BLANK;
        endcase
    end

    // State register; reset parks the chain in blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // Remember that the post-reset transfer has not been issued yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else if (state_q == ST_BLANK) begin
            first_q <= 1'b0;
        end
    end

    assign run   = (state_q == ST_RUN);
    assign blank = !run;
    assign latch = (state_q == ST_LATCH);

    // R9
    latch_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> !latch);

    // R9
    release_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank) |-> $past(latch, 2));

endmodule

// File: rtl/gs_chain_timing.sv
// Top level of the grayscale chain controller. Ties the grayscale clock
// generator, the frame shifter and the cycle sequencer together.
// XFER_IN_BLANK selects the transfer schedule. Assumes for the in-cycle
// schedule that 2*SCK_DIV*N_DEV*192 is shorter than one grayscale frame.
module gs_chain_timing
    import gs_chain_pkg::*;
#(
    parameter int N_DEV         = 2,
    parameter int SCK_DIV       = 1,
    parameter int GS_DIV        = 1,
    parameter int GS_STEPS      = 4096,
    parameter bit XFER_IN_BLANK = 1'b0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                host_we,
    input  logic [$clog2(N_DEV*CH_PER_DEV)-1:0] host_chan,
    input  logic [LVL_W-1:0]                    host_level,
    input  logic                                host_commit,
    output logic                                gs_clk_o,
    output logic                                blank_o,
    output logic                                latch_o,
    output logic                                ser_clk_o,
    output logic                                ser_dat_o
);
    logic run;
    logic gs_done;
    logic xfer_go;
    logic xfer_busy;

    gs_clock_gen #(
        .DIV   (GS_DIV),
        .STEPS (GS_STEPS)
    ) u_gs (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .gs_clk (gs_clk_o),
        .done   (gs_done)
    );

    frame_shifter #(
        .N_DEV   (N_DEV),
        .SCK_DIV (SCK_DIV)
    ) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_chan   (host_chan),
        .host_level  (host_level),
        .host_commit (host_commit),
        .go          (xfer_go),
        .busy        (xfer_busy),
        .ser_clk     (ser_clk_o),
        .ser_dat     (ser_dat_o)
    );

    cycle_seq #(
        .XFER_IN_BLANK (XFER_IN_BLANK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .gs_done   (gs_done),
        .xfer_busy (xfer_busy),
        .run       (run),
        .blank     (blank_o),
        .latch     (latch_o),
        .go        (xfer_go)
    );

    // R9
    latch_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> (blank_o && !ser_clk_o && !xfer_busy && $past(!xfer_busy)));

    generate
        if (XFER_IN_BLANK) begin : g_blank_sched
            // R5
            shift_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ser_clk_o |-> blank_o);
        end
    endgenerate

endmodule

// File: tb/test_gs_chain_timing.sv
// Port monitor: records, per instance, the last latched frame, its bit
// count, the blanking width, grayscale edges per frame and where serial
// edges fell. Sampled on the falling system clock edge.
module test_mon #(
    parameter int FRAME = 384
) (
    input  logic             clk,
    input  logic             blank,
    input  logic             latch,
    input  logic             sclk,
    input  logic             sdo,
    input  logic             gsclk,
    output logic [FRAME-1:0] frame,
    output int               bits_last,
    output int               lat_cnt,
    output int               blank_w_last,
    output int               gs_last,
    output int               sck_run_last,
    output int               sck_blk_last,
    output int               bad_latch
);
    logic [FRAME-1:0] cap = '0;
    int nbits = 0, bw = 0, gsr = 0, s_run = 0, s_blk = 0;
    logic p_sclk = 0, p_gs = 0, p_blank = 1;

    initial begin
        frame = '0; bits_last = 0; lat_cnt = 0; blank_w_last = 0;
        gs_last = 0; sck_run_last = 0; sck_blk_last = 0; bad_latch = 0;
    end

    always @(negedge clk) begin
        p_sclk  <= sclk;
        p_gs    <= gsclk;
        p_blank <= blank;
        if (sclk && !p_sclk) begin
            if (nbits < FRAME) cap[FRAME-1-nbits] <= sdo;
            nbits <= nbits + 1;
            if (blank) s_blk <= s_blk + 1; else s_run <= s_run + 1;
        end
        if (gsclk && !p_gs && !blank) gsr <= gsr + 1;
        if (blank) bw <= bw + 1;
        if (!blank && p_blank) begin
            blank_w_last <= bw; bw <= 0;
            sck_blk_last <= s_blk; s_blk <= 0;
        end
        if (blank && !p_blank) begin
            gs_last <= gsr; gsr <= 0;
            sck_run_last <= s_run; s_run <= 0;
        end
        if (latch) begin
            frame     <= cap;
            bits_last <= nbits;
            nbits     <= 0;
            lat_cnt   <= lat_cnt + 1;
            if (!blank || sclk) bad_latch <= bad_latch + 1;
        end
    end
endmodule

module test_gs_chain_timing;
    localparam int  CLK_P   = 10;
    localparam int  N_DEV   = 2;
    localparam int  SCK_DIV = 1;
    localparam int  NCH     = N_DEV * 16;
    localparam int  FRAME   = N_DEV * 192;
    localparam int  CH_W    = $clog2(NCH);
    localparam int  BLK1_W  = 2 * SCK_DIV * FRAME + 4;

    // Table of level patterns: {base, step}, level(k) = base + step*k mod 4096.
    localparam logic [23:0] VEC [4] = '{
        {12'hFFF, 12'h000},
        {12'h000, 12'h081},
        {12'hA5C, 12'h111},
        {12'h800, 12'hFFF}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic host_we = 0;
    logic [CH_W-1:0] host_chan = '0;
    logic [11:0] host_level = '0;
    logic host_commit = 0;

    logic gs0, bl0, la0, sc0, sd0;
    logic gs1, bl1, la1, sc1, sd1;

    logic [FRAME-1:0] fr0, fr1;
    int bits0, bits1, lat0, lat1, bw0, bw1, gsl0, gsl1;
    int sr0, sr1, sb0, sb1, bad0, bad1;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [FRAME-1:0] exp_cur;

    always #(CLK_P/2) clk = ~clk;

    gs_chain_timing #(.N_DEV(N_DEV), .SCK_DIV(SCK_DIV), .XFER_IN_BLANK(1'b0)) i_gs_chain_timing (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_chan(host_chan),
        .host_level(host_level), .host_commit(host_commit),
        .gs_clk_o(gs0), .blank_o(bl0), .latch_o(la0), .ser_clk_o(sc0), .ser_dat_o(sd0));

    gs_chain_timing #(.N_DEV(N_DEV), .SCK_DIV(SCK_DIV), .XFER_IN_BLANK(1'b1)) i_gs_chain_timing_blk (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_chan(host_chan),
        .host_level(host_level), .host_commit(host_commit),
        .gs_clk_o(gs1), .blank_o(bl1), .latch_o(la1), .ser_clk_o(sc1), .ser_dat_o(sd1));

    test_mon #(.FRAME(FRAME)) i_mon0 (.clk(clk), .blank(bl0), .latch(la0), .sclk(sc0),
        .sdo(sd0), .gsclk(gs0), .frame(fr0), .bits_last(bits0), .lat_cnt(lat0),
        .blank_w_last(bw0), .gs_last(gsl0), .sck_run_last(sr0), .sck_blk_last(sb0),
        .bad_latch(bad0));

    test_mon #(.FRAME(FRAME)) i_mon1 (.clk(clk), .blank(bl1), .latch(la1), .sclk(sc1),
        .sdo(sd1), .gsclk(gs1), .frame(fr1), .bits_last(bits1), .lat_cnt(lat1),
        .blank_w_last(bw1), .gs_last(gsl1), .sck_run_last(sr1), .sck_blk_last(sb1),
        .bad_latch(bad1));

    task automatic chk_num(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_frame(input string tag, input logic [FRAME-1:0] act,
                             input logic [FRAME-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R3: channel k sits at bits [12k+11:12k]; the wire sends the top bit first.
    function automatic logic [FRAME-1:0] mk_frame(input logic [11:0] b, input logic [11:0] s);
        logic [FRAME-1:0] r;
        for (int k = 0; k < NCH; k++) r[k*12 +: 12] = 12'(b + 12'(s * k));
        return r;
    endfunction

    task automatic load(input logic [11:0] b, input logic [11:0] s, input bit commit);
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            host_we = 1; host_chan = CH_W'(k); host_level = 12'(b + 12'(s * k));
        end
        @(negedge clk);
        host_we = 0;
        if (commit) begin
            host_commit = 1;
            @(negedge clk);
            host_commit = 0;
        end
    endtask

    task automatic wait_lat(input int n, input bit both);
        int s0 = lat0, s1 = lat1;
        while ((lat0 < s0 + n) || (both && (lat1 < s1 + n))) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: outputs under reset
        chk_num("R8 blank under reset", {bl0, bl1}, 2'b11);
        chk_num("R8 latch/sclk/sdat/gsclk under reset",
                {la0, sc0, sd0, gs0, la1, sc1, sd1, gs1}, 0);
        rst_n = 1;

        // R8: first latched frame is all zeros
        wait_lat(1, 1);
        chk_frame("R8 first frame in-cycle", fr0, '0);
        chk_frame("R8 first frame in-blank", fr1, '0);
        chk_num("R2 first frame bit count", bits0 + bits1, 2 * FRAME);

        // R3/R7: table of level patterns walked by one loop
        for (int v = 0; v < 4; v++) begin
            exp_cur = mk_frame(VEC[v][23:12], VEC[v][11:0]);
            load(VEC[v][23:12], VEC[v][11:0], 1'b1);
            wait_lat(2, 1);
            chk_frame($sformatf("R3 R7 pattern %0d in-cycle", v), fr0, exp_cur);
            chk_frame($sformatf("R3 R7 pattern %0d in-blank", v), fr1, exp_cur);
            chk_num($sformatf("R2 pattern %0d bit counts", v), bits0 + bits1, 2 * FRAME);
        end

        // R1/R4/R5/R6: per-cycle timing measured at the ports
        chk_num("R1 gs edges per frame in-cycle", gsl0, 4096);
        chk_num("R1 gs edges per frame in-blank", gsl1, 4096);
        chk_num("R4 blank width in-cycle", bw0, 4);
        chk_num("R4 serial edges during run in-cycle", sr0, FRAME);
        chk_num("R4 serial edges during blank in-cycle", sb0, 0);
        chk_num("R5 blank width in-blank", bw1, BLK1_W);
        chk_num("R5 serial edges during run in-blank", sr1, 0);

        // R7/R6: writes without commit leave the wire unchanged
        load(12'h123, 12'h045, 1'b0);
        wait_lat(2, 1);
        chk_frame("R7 no commit in-cycle", fr0, exp_cur);
        chk_frame("R6 R7 no commit in-blank", fr1, exp_cur);
        chk_num("R6 full frame without commit", sb1, FRAME);
        host_commit = 1; @(negedge clk); host_commit = 0;
        exp_cur = mk_frame(12'h123, 12'h045);
        wait_lat(2, 1);
        chk_frame("R7 late commit in-cycle", fr0, exp_cur);
        chk_frame("R7 late commit in-blank", fr1, exp_cur);

        // R10: write and commit during an in-cycle transfer
        while (!bl0) @(negedge clk);
        while (bl0) @(negedge clk);
        repeat (10) @(negedge clk);
        load(12'h5A5, 12'h00F, 1'b1);
        wait_lat(1, 0);
        chk_frame("R10 frame in flight unchanged", fr0, exp_cur);
        wait_lat(1, 0);
        chk_frame("R10 next frame updated", fr0, mk_frame(12'h5A5, 12'h00F));

        // R9: every latch seen inside blanking with the serial clock low
        chk_num("R9 latches outside blank in-cycle", bad0, 0);
        chk_num("R9 latches outside blank in-blank", bad1, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule